// File: doc/BRIEF.md
# Nonvolatile Array Refresh Sequencer

This block is a hardware sequencer that refreshes a byte-addressable nonvolatile array. It reads every location and writes the same value back. It does not touch the array directly. It acts as a bus master on the register interface of a guarded write controller, and it issues the same register accesses, in the same order, that a software refresh loop would.

After a start request, the sequencer does the following:

- It clears both address bytes.
- It selects the data array, masks interrupts and turns on write-enable.
- It walks the address upward. For each byte it reads the location and writes the captured value back. Before each write it issues the two-step unlock handshake, then starts the write and polls until the write completes.
- The low address byte advances first. The high byte is written only when the low byte rolls over.
- When the last location of the configured array size is done, it drops write-enable, releases the interrupt mask and pulses done.

If the controller reports a write error during a poll, the sequencer aborts. It drops write-enable and raises a sticky error flag.

Top module: `nvr_refresh_seq`

## Requirements
- R1: Out of reset, busy_o, done_o, irq_mask_o, error_o and bus_valid_o are all low.
- R2: When start_i is high in idle, the sequencer issues these accesses in order: write address-low (select 0) with 0x00, write address-high (select 1) with 0x00, write control (select 3) with 0x00 to select the data array, then write control with 0x04 (write-enable, bit 2).
- R3: For each address, the sequencer issues these accesses in order: write control with 0x05 (write-enable plus read-start, bit 0), read data (select 2), write data with the byte returned for that read, write unlock (select 4) with 0x55, write unlock with 0xAA, write control with 0x06 (write-enable plus write-start, bit 1). Read data returns on bus_rdata_i in the cycle after the read access.
- R4: After starting a write, the sequencer reads control repeatedly while bit 1 reads back as 1. It makes no address write until bit 1 reads back as 0.
- R5: Once the write completes, the sequencer writes address-low with the incremented low byte. Only if that byte wrapped to 0x00 does it then write address-high with the incremented high byte.
- R6: After the location at ARRAY_BYTES-1 completes, the sequencer writes control with 0x00. It then raises done_o for exactly one cycle and returns to idle, with busy_o low on the following cycle.
- R7: irq_mask_o rises before write-enable is set and stays high through every unlock write. It is low whenever the sequencer is idle and low in the done cycle.
- R8: A start_i pulse while busy_o is high has no effect on the access sequence.
- R9: If a control read shows bit 4 (write error) set, the sequencer writes control with 0x00 and returns to idle. It does not pulse done_o, and error_o stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a refresh pass |
| busy_o | output | 1 | Refresh pass in progress |
| done_o | output | 1 | One-cycle pulse when a pass completes |
| error_o | output | 1 | Sticky flag set when a pass aborts on a write error |
| irq_mask_o | output | 1 | Interrupt mask held while the array is write-enabled |
| bus_valid_o | output | 1 | Register access this cycle |
| bus_write_o | output | 1 | 1 = write access, 0 = read access |
| bus_sel_o | output | 3 | Register select: 0 address low, 1 address high, 2 data, 3 control, 4 unlock |
| bus_wdata_o | output | 8 | Write data (zero on reads) |
| bus_rdata_i | input | 8 | Read data, valid the cycle after a read access |

## Verification
Two situations are hard to reach from the ports. The first is a write error that arrives partway through the array, after the high address byte has already advanced. The second is a controller that holds write-start for a varying number of polls. The bench's controller model gives each write a completion latency that depends on its address. It can also be told to fail the write at one chosen address above 255, so that the abort path is reached from deep in the address walk. Start pulses are injected in the middle of a pass, and the bus trace is compared against the expected trace, so a restart or a skipped step would show up as a mismatch.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

  localparam int unsigned SEL_W  = 3;
  localparam int unsigned BYTE_W = 8;

  localparam logic [SEL_W-1:0] SEL_ADDR_LO = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ADDR_HI = 3'd1;
  localparam logic [SEL_W-1:0] SEL_DATA    = 3'd2;
  localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd3;
  localparam logic [SEL_W-1:0] SEL_UNLOCK  = 3'd4;

  localparam int unsigned CTRL_RD_BIT  = 0;
  localparam int unsigned CTRL_WR_BIT  = 1;
  localparam int unsigned CTRL_WEN_BIT = 2;
  localparam int unsigned CTRL_ERR_BIT = 4;

  localparam logic [BYTE_W-1:0] CTRL_IDLE   = 8'h00;
  localparam logic [BYTE_W-1:0] CTRL_WEN    = 8'h04;
  localparam logic [BYTE_W-1:0] CTRL_WEN_RD = 8'h05;
  localparam logic [BYTE_W-1:0] CTRL_WEN_WR = 8'h06;

  localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_CLR_LO,
    ST_CLR_HI,
    ST_SEL_ARR,
    ST_MASK_IRQ,
    ST_SET_WEN,
    ST_RD_GO,
    ST_RD_DATA,
    ST_RD_CAP,
    ST_WR_DATA,
    ST_UNLK_A,
    ST_UNLK_B,
    ST_WR_GO,
    ST_POLL_RD,
    ST_POLL_CHK,
    ST_ADV_LO,
    ST_ADV_HI,
    ST_CLR_WEN,
    ST_UNMASK,
    ST_ABORT
  } seq_state_t;

  typedef struct packed {
    logic              valid;
    logic              write;
    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] wdata;
  } bus_op_t;

endpackage

// File: rtl/nvr_addr_walker.sv
module nvr_addr_walker
  import nvr_pkg::*;
#(
  parameter int unsigned ARRAY_BYTES = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_lo_i,
  input  logic              clr_hi_i,
  input  logic              step_lo_i,
  input  logic              step_hi_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_next_o,
  output logic [BYTE_W-1:0] hi_next_o,
  output logic              lo_wrap_o,
  output logic              last_o
);

  localparam int unsigned ADDR_W    = 2 * BYTE_W;
  localparam int unsigned LAST_ADDR = ARRAY_BYTES - 1;
  localparam logic [ADDR_W-1:0] LAST_VEC = LAST_ADDR[ADDR_W-1:0];

  logic [BYTE_W-1:0] lo_q, lo_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic              lo_en, hi_en;

  assign lo_next_o = lo_q + 8'd1;
  assign hi_next_o = hi_q + 8'd1;
  assign lo_wrap_o = (lo_q == 8'hFF);
  assign last_o    = ({hi_q, lo_q} == LAST_VEC);

  always_comb begin
    lo_en = clr_lo_i | step_lo_i;
    hi_en = clr_hi_i | step_hi_i;
    lo_d  = clr_lo_i ? '0 : lo_next_o;
    hi_d  = clr_hi_i ? '0 : hi_next_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_en) lo_q <= lo_d;
      if (hi_en) hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

endmodule

// File: rtl/nvr_seq_fsm.sv
module nvr_seq_fsm
  import nvr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] rdata_i,
  input  logic              lo_wrap_i,
  input  logic              last_i,
  output seq_state_t        state_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              error_o
);

  seq_state_t        state_q, state_d;
  logic [BYTE_W-1:0] data_q;
  logic              data_en;
  logic              err_q, err_d, err_en;
  logic              poll_err, poll_busy;

  assign poll_err  = rdata_i[CTRL_ERR_BIT];
  assign poll_busy = rdata_i[CTRL_WR_BIT];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_CLR_LO;
      ST_CLR_LO:   state_d = ST_CLR_HI;
      ST_CLR_HI:   state_d = ST_SEL_ARR;
      ST_SEL_ARR:  state_d = ST_MASK_IRQ;
      ST_MASK_IRQ: state_d = ST_SET_WEN;
      ST_SET_WEN:  state_d = ST_RD_GO;
      ST_RD_GO:    state_d = ST_RD_DATA;
      ST_RD_DATA:  state_d = ST_RD_CAP;
      ST_RD_CAP:   state_d = ST_WR_DATA;
      ST_WR_DATA:  state_d = ST_UNLK_A;
      ST_UNLK_A:   state_d = ST_UNLK_B;
      ST_UNLK_B:   state_d = ST_WR_GO;
      ST_WR_GO:    state_d = ST_POLL_RD;
      ST_POLL_RD:  state_d = ST_POLL_CHK;
      ST_POLL_CHK: begin
        if (poll_err)       state_d = ST_ABORT;
        else if (poll_busy) state_d = ST_POLL_RD;
        else if (last_i)    state_d = ST_CLR_WEN;
        else                state_d = ST_ADV_LO;
      end
      ST_ADV_LO:   state_d = lo_wrap_i ? ST_ADV_HI : ST_RD_GO;
      ST_ADV_HI:   state_d = ST_RD_GO;
      ST_CLR_WEN:  state_d = ST_UNMASK;
      ST_UNMASK:   state_d = ST_IDLE;
      ST_ABORT:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    data_en = (state_q == ST_RD_CAP);
    err_en  = 1'b0;
    err_d   = err_q;
    if ((state_q == ST_IDLE) && start_i) begin
      err_en = 1'b1;
      err_d  = 1'b0;
    end else if ((state_q == ST_POLL_CHK) && poll_err) begin
      err_en = 1'b1;
      err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (data_en) data_q <= rdata_i;
      if (err_en)  err_q  <= err_d;
    end
  end

  assign state_o = state_q;
  assign data_o  = data_q;
  assign error_o = err_q;

endmodule

// File: rtl/nvr_bus_encode.sv
module nvr_bus_encode
  import nvr_pkg::*;
(
  input  seq_state_t        state_i,
  input  logic [BYTE_W-1:0] lo_next_i,
  input  logic [BYTE_W-1:0] hi_next_i,
  input  logic [BYTE_W-1:0] data_i,
  output bus_op_t           op_o,
  output logic              mask_o
);

  function automatic bus_op_t wr_op(logic [SEL_W-1:0] sel, logic [BYTE_W-1:0] val);
    bus_op_t o;
    o.valid = 1'b1;
    o.write = 1'b1;
    o.sel   = sel;
    o.wdata = val;
    return o;
  endfunction

  function automatic bus_op_t rd_op(logic [SEL_W-1:0] sel);
    bus_op_t o;
    o.valid = 1'b1;
    o.write = 1'b0;
    o.sel   = sel;
    o.wdata = '0;
    return o;
  endfunction

  always_comb begin
    op_o = '0;
    unique case (state_i)
      ST_CLR_LO:  op_o = wr_op(SEL_ADDR_LO, 8'h00);
      ST_CLR_HI:  op_o = wr_op(SEL_ADDR_HI, 8'h00);
      ST_SEL_ARR: op_o = wr_op(SEL_CTRL, CTRL_IDLE);
      ST_SET_WEN: op_o = wr_op(SEL_CTRL, CTRL_WEN);
      ST_RD_GO:   op_o = wr_op(SEL_CTRL, CTRL_WEN_RD);
      ST_RD_DATA: op_o = rd_op(SEL_DATA);
      ST_WR_DATA: op_o = wr_op(SEL_DATA, data_i);
      ST_UNLK_A:  op_o = wr_op(SEL_UNLOCK, KEY_FIRST);
      ST_UNLK_B:  op_o = wr_op(SEL_UNLOCK, KEY_SECOND);
      ST_WR_GO:   op_o = wr_op(SEL_CTRL, CTRL_WEN_WR);
      ST_POLL_RD: op_o = rd_op(SEL_CTRL);
      ST_ADV_LO:  op_o = wr_op(SEL_ADDR_LO, lo_next_i);
      ST_ADV_HI:  op_o = wr_op(SEL_ADDR_HI, hi_next_i);
      ST_CLR_WEN: op_o = wr_op(SEL_CTRL, CTRL_IDLE);
      ST_ABORT:   op_o = wr_op(SEL_CTRL, CTRL_IDLE);
      default:    op_o = '0;
    endcase
  end

  always_comb begin
    unique case (state_i)
      ST_MASK_IRQ, ST_SET_WEN, ST_RD_GO, ST_RD_DATA, ST_RD_CAP,
      ST_WR_DATA, ST_UNLK_A, ST_UNLK_B, ST_WR_GO, ST_POLL_RD,
      ST_POLL_CHK, ST_ADV_LO, ST_ADV_HI, ST_CLR_WEN: mask_o = 1'b1;
      default:                                        mask_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/nvr_refresh_seq.sv
module nvr_refresh_seq
  import nvr_pkg::*;
#(
  parameter int unsigned ARRAY_BYTES = 65536
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       error_o,
  output logic       irq_mask_o,
  output logic       bus_valid_o,
  output logic       bus_write_o,
  output logic [2:0] bus_sel_o,
  output logic [7:0] bus_wdata_o,
  input  logic [7:0] bus_rdata_i
);

  seq_state_t        state;
  logic [BYTE_W-1:0] lo, hi, lo_next, hi_next, data;
  logic              lo_wrap, last;
  bus_op_t           op;

  nvr_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rdata_i   (bus_rdata_i),
    .lo_wrap_i (lo_wrap),
    .last_i    (last),
    .state_o   (state),
    .data_o    (data),
    .error_o   (error_o)
  );

  nvr_addr_walker #(.ARRAY_BYTES(ARRAY_BYTES)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_lo_i  (state == ST_CLR_LO),
    .clr_hi_i  (state == ST_CLR_HI),
    .step_lo_i (state == ST_ADV_LO),
    .step_hi_i (state == ST_ADV_HI),
    .lo_o      (lo),
    .hi_o      (hi),
    .lo_next_o (lo_next),
    .hi_next_o (hi_next),
    .lo_wrap_o (lo_wrap),
    .last_o    (last)
  );

  nvr_bus_encode u_enc (
    .state_i   (state),
    .lo_next_i (lo_next),
    .hi_next_i (hi_next),
    .data_i    (data),
    .op_o      (op),
    .mask_o    (irq_mask_o)
  );

  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_UNMASK);
  assign bus_valid_o = op.valid;
  assign bus_write_o = op.write;
  assign bus_sel_o   = op.sel;
  assign bus_wdata_o = op.wdata;

  logic unused_addr;
  assign unused_addr = ^{lo, hi};

endmodule

// File: rtl/nvr_refresh_seq_chk.sv
module nvr_refresh_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       done_o,
  input logic       error_o,
  input logic       irq_mask_o,
  input logic       bus_valid_o,
  input logic       bus_write_o,
  input logic [2:0] bus_sel_o,
  input logic [7:0] bus_wdata_o
);

  logic wr_key1, wr_key2, wr_go, wr_addr;
  assign wr_key1 = bus_valid_o && bus_write_o && (bus_sel_o == 3'd4) && (bus_wdata_o == 8'h55);
  assign wr_key2 = bus_valid_o && bus_write_o && (bus_sel_o == 3'd4) && (bus_wdata_o == 8'hAA);
  assign wr_go   = bus_valid_o && bus_write_o && (bus_sel_o == 3'd3) && (bus_wdata_o == 8'h06);
  assign wr_addr = bus_valid_o && bus_write_o && (bus_sel_o <= 3'd1);

  // R1: no bus traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_valid_o);

  // R3: second key follows first key directly
  a_r3_key_order: assert property (@(posedge clk) disable iff (!rst_n)
    wr_key2 |-> $past(wr_key1));

  // R3: write-start follows second key directly
  a_r3_go_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> $past(wr_key2));

  // R4: address never moves in the cycle right after a write start
  a_r4_no_addr_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_addr);

  // R6: done lasts one cycle and ends the pass
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R7: unlock writes only while interrupts are masked
  a_r7_mask_on_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key1 || wr_key2) |-> irq_mask_o);

  // R7: mask is never held outside a pass or in the done cycle
  a_r7_mask_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask_o |-> (busy_o && !done_o));

  // R9: an aborted pass reports no completion
  a_r9_error_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !done_o);

endmodule

bind nvr_refresh_seq nvr_refresh_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .error_o     (error_o),
  .irq_mask_o  (irq_mask_o),
  .bus_valid_o (bus_valid_o),
  .bus_write_o (bus_write_o),
  .bus_sel_o   (bus_sel_o),
  .bus_wdata_o (bus_wdata_o)
);

// File: tb/nvr_refresh_seq_tb_top.sv
module nvr_refresh_seq_tb_top;

  localparam int NBYTES = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, done, error, mask;
  logic       bvalid, bwrite;
  logic [2:0] bsel;
  logic [7:0] bwdata;
  logic [7:0] brdata;

  always #2 clk = ~clk;

  nvr_refresh_seq #(.ARRAY_BYTES(NBYTES)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .busy_o      (busy),
    .done_o      (done),
    .error_o     (error),
    .irq_mask_o  (mask),
    .bus_valid_o (bvalid),
    .bus_write_o (bwrite),
    .bus_sel_o   (bsel),
    .bus_wdata_o (bwdata),
    .bus_rdata_i (brdata)
  );

  // settings owned by the stimulus process
  int pat_seed = 0;
  int lat_seed = 0;
  int err_addr = -1;

  function automatic logic [7:0] pat(int a, int s);
    int v;
    v = a * 7 + s + (a >> 8) * 13;
    return v[7:0];
  endfunction

  // controller model, owned by this always block
  logic [7:0] m_lo, m_hi, m_data;
  logic       m_wen, m_err;
  int         m_key, m_cnt, m_wa, m_commits, m_bad_commits, m_viol;
  logic [7:0] m_wd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo <= '0; m_hi <= '0; m_data <= '0; m_wen <= 1'b0; m_err <= 1'b0;
      m_key <= 0; m_cnt <= 0; m_wa <= 0; m_wd <= '0; brdata <= '0;
      m_commits <= 0; m_bad_commits <= 0; m_viol <= 0;
    end else begin
      if (m_cnt > 0) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin
          if (m_wa == err_addr) m_err <= 1'b1;
          else begin
            m_commits <= m_commits + 1;
            if (m_wd != pat(m_wa, pat_seed)) m_bad_commits <= m_bad_commits + 1;
          end
        end
      end
      if (bvalid && bwrite) begin
        case (bsel)
          3'd0: begin m_lo <= bwdata; if (m_cnt > 0) m_viol <= m_viol + 1; end
          3'd1: begin m_hi <= bwdata; if (m_cnt > 0) m_viol <= m_viol + 1; end
          3'd2: m_data <= bwdata;
          3'd4: begin
            if (bwdata == 8'h55) m_key <= 1;
            else if (bwdata == 8'hAA && m_key == 1) m_key <= 2;
            else m_key <= 0;
          end
          3'd3: begin
            m_wen <= bwdata[2];
            if (bwdata == 8'h04) m_err <= 1'b0;
            if (bwdata[0]) m_data <= pat({m_hi, m_lo}, pat_seed);
            if (bwdata[1]) begin
              if (bwdata[2] && m_key == 2) begin
                m_cnt <= 1 + (({m_hi, m_lo} + lat_seed) & 3);
                m_wa  <= {m_hi, m_lo};
                m_wd  <= m_data;
              end else m_viol <= m_viol + 1;
              m_key <= 0;
            end
          end
          default: ;
        endcase
      end else if (bvalid) begin
        case (bsel)
          3'd2:    brdata <= m_data;
          3'd3:    brdata <= {3'b000, m_err, 1'b0, m_wen, (m_cnt > 0), 1'b0};
          default: brdata <= 8'h00;
        endcase
      end
    end
  end

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int done_cnt = 0;
  logic [11:0] exp_q[$];
  logic last_poll = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    logic [11:0] op, e;
    @(negedge clk);
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (done) begin
      done_cnt++;
      chk(!mask, "R7", "mask in done cycle", mask, 0);
    end
    if (!busy && mask) chk(0, "R7", "mask while idle", mask, 0);
    if (bvalid && bwrite && bsel == 3'd4) chk(mask, "R7", "mask at unlock", mask, 1);
    if (bvalid) begin
      op = {bwrite, bsel, bwrite ? bwdata : 8'h00};
      if (!(op == 12'h300 && last_poll)) begin
        if (exp_q.size() == 0) chk(0, "R3", "unexpected bus op", op, 0);
        else begin
          e = exp_q.pop_front();
          chk(op == e, "R3", "bus op order", op, e);
        end
      end
      last_poll = (op == 12'h300);
    end
  endtask

  function automatic logic [11:0] w(int sel, logic [7:0] d);
    return {1'b1, sel[2:0], d};
  endfunction

  task automatic build(int n, int ea, int seed);
    exp_q.delete();
    // R2 setup
    exp_q.push_back(w(0, 8'h00));
    exp_q.push_back(w(1, 8'h00));
    exp_q.push_back(w(3, 8'h00));
    exp_q.push_back(w(3, 8'h04));
    for (int a = 0; a < n; a++) begin
      // R3 per-byte order
      exp_q.push_back(w(3, 8'h05));
      exp_q.push_back(12'h200);
      exp_q.push_back(w(2, pat(a, seed)));
      exp_q.push_back(w(4, 8'h55));
      exp_q.push_back(w(4, 8'hAA));
      exp_q.push_back(w(3, 8'h06));
      exp_q.push_back(12'h300);          // R4 poll (repeats collapsed)
      if (a == ea || a == n - 1) begin
        exp_q.push_back(w(3, 8'h00));    // R6 / R9
        break;
      end
      // R5 address advance
      exp_q.push_back(w(0, 8'((a + 1) & 255)));
      if (((a + 1) & 255) == 0) exp_q.push_back(w(1, 8'((a + 1) >> 8)));
    end
  endtask

  task automatic run(int ea, int seed, int lseed, bit poke);
    int c0, k;
    pat_seed = seed; lat_seed = lseed; err_addr = ea;
    build(NBYTES, ea, seed);
    c0 = m_commits;
    done_cnt = 0;
    last_poll = 1'b0;
    start = 1'b1;
    cycle();
    start = 1'b0;
    chk(busy, "R2", "busy after start", busy, 1);
    chk(!error, "R9", "error cleared by start", error, 0);
    k = 0;
    while (busy && k < 40000) begin
      // R8: start pulses mid-pass
      start = poke && (k == 30 || k == 31 || k == 3000);
      cycle();
      k++;
    end
    start = 1'b0;
    cycle();
    chk(exp_q.size() == 0, "R6", "ops left unissued", exp_q.size(), 0);
    chk(m_bad_commits == 0, "R3", "rewritten value mismatch", m_bad_commits, 0);
    chk(m_viol == 0, "R4", "write/address protocol violations", m_viol, 0);
    chk(!busy && !mask, "R6", "idle after pass", {busy, mask}, 0);
    if (ea < 0) begin
      chk(m_commits - c0 == NBYTES, "R6", "bytes refreshed", m_commits - c0, NBYTES);
      chk(done_cnt == 1, "R6", "done pulses", done_cnt, 1);
      chk(!error, "R9", "no error on clean pass", error, 0);
    end else begin
      chk(m_commits - c0 == ea, "R9", "bytes before abort", m_commits - c0, ea);
      chk(done_cnt == 0, "R9", "no done on abort", done_cnt, 0);
      chk(error, "R9", "error flag held", error, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mask && !error && !bvalid, "R1", "reset outputs",
        {busy, done, mask, error, bvalid}, 0);
    rst_n = 1'b1;
    cycle();
    chk(!busy && !bvalid, "R1", "idle after reset", {busy, bvalid}, 0);
    run(-1, 3, 0, 1'b1);
    run(300, 41, 2, 1'b0);
    repeat (5) cycle();
    chk(error, "R9", "error stays while idle", error, 1);
    run(-1, 200, 1, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule